// File: doc/BRIEF.md
# NEC Infrared Remote Key Decoder

This block listens to the demodulated output of an infrared receiver module, which idles high and goes low while carrier is present (a "mark"). It measures the length of every mark and space in microsecond ticks, recognises the pulse-distance frames that NEC-style remotes send, and checks the integrity of each 32-bit frame. A command byte that appears in a parameter table is turned into a 4-bit key code. The code is held on `key`, and a processor is told about it with a one-cycle `irq` pulse.

The short repeat frame that a remote sends while a button is held fires `irq` again with the last key. It does so only while a hold-off window that starts at the last accepted key is still open. Every timing value, the tolerance, the repeat window, the input synchroniser depth and the command-to-key table are parameters. The same block therefore serves any remote and any tick rate.

Top module: `ir_key_decoder`

## Requirements
- R1: After reset, `key` is 0, `key_valid` is 0 and `irq` is 0.
- R2: A well-formed frame whose command is in the table loads that key's code into `key`, sets `key_valid`, and produces exactly one `irq` pulse one clock long. `key` does not change at any other time.
- R3: The default table maps command bytes to key codes as follows: 0x45 to 0111 (power), 0x0C to 0001, 0x18 to 0010, 0x5E to 0011, 0x1C to 0101, 0x46 to 0110 (up), 0x15 to 0100 (down), 0x44 to 1000 (left), 0x43 to 1001 (right). Any address byte is accepted.
- R4: A frame is a leader mark (nominal 9 ms) and a leader space (4.5 ms), followed by 32 bits sent LSB first. Each bit is a 562.5 µs mark and then a space: about 562.5 µs for 0 and about 1.69 ms for 1. Byte 0 is the address, byte 1 is its complement, byte 2 is the command and byte 3 is its complement.
- R5: A frame in which the address byte or the command byte does not match the complement of the byte after it raises no `irq` and leaves `key` unchanged.
- R6: A frame that passes the check but whose command is not in the table raises no `irq` and leaves `key` unchanged. It also closes the repeat window.
- R7: A repeat frame is a leader mark followed by a 2.25 ms space. It gives one `irq` pulse with `key` unchanged when a key is valid and the repeat window (nominal 110 ms) is open. Each accepted repeat restarts the window.
- R8: A repeat frame gives no `irq` if no key has been received yet, or if the window has expired.
- R9: A mark or space counts only when its length lies within ±TOL_PCT percent (20 by default) of its nominal value. Anything outside that range abandons the frame.
- R10: If no edge arrives for longer than the timeout (12 ms) while a frame is in progress, the decoder returns to idle, so the next frame decodes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_n | input | 1 | Demodulated IR line, low while carrier is present; asynchronous |
| us_tick | input | 1 | One-cycle strobe, one per microsecond of timing |
| key | output | 4 | Last decoded key code |
| key_valid | output | 1 | High once any key has been decoded |
| irq | output | 1 | One-cycle pulse for each new key or accepted repeat |

## Verification
The bench ties `us_tick` high and scales every duration down by about fifty: a 180-cycle leader mark, a 12-cycle bit mark, 12- and 34-cycle bit spaces, a 240-cycle timeout and a 2000-cycle repeat window. This keeps each frame near 1500 cycles. At that scale the bench can send all nine table commands, the checksum and unmapped cases, and leaders that are just inside and just outside the tolerance. It can also wait out the repeat window in both directions, including a second repeat that is accepted only because the first one restarted the window. The default 2-stage synchroniser and the default command table are kept. Commands such as 0x0C, whose bit-reversed value is not in the table, show that the bit order is LSB first.

// File: rtl/ir_key_pkg.sv
package ir_key_pkg;

   typedef enum logic [1:0] {
      S_IDLE,
      S_LEAD_SPACE,
      S_BIT_MARK,
      S_BIT_SPACE
   } nec_state_e;

   localparam int FRAME_BITS = 32;
   localparam int DEF_KEYS   = 9;

   // Index i of DEF_CMD maps to index i of DEF_CODE.
   localparam logic [DEF_KEYS-1:0][7:0] DEF_CMD =
      {8'h43, 8'h44, 8'h15, 8'h46, 8'h1C, 8'h5E, 8'h18, 8'h0C, 8'h45};
   localparam logic [DEF_KEYS-1:0][3:0] DEF_CODE =
      {4'h9, 4'h8, 4'h4, 4'h6, 4'h5, 4'h3, 4'h2, 4'h1, 4'h7};

   function automatic int win_lo(input int nom, input int tol);
      return nom - (nom * tol) / 100;
   endfunction

   function automatic int win_hi(input int nom, input int tol);
      return nom + (nom * tol) / 100;
   endfunction

   function automatic logic in_win(input int d, input int nom, input int tol);
      return (d >= win_lo(nom, tol)) && (d <= win_hi(nom, tol));
   endfunction

endpackage

// File: rtl/ir_edge_timer.sv
module ir_edge_timer #(
   parameter int SYNC_STAGES = 2,
   parameter int TIMEOUT_US  = 12000,
   localparam int CNT_W      = $clog2(TIMEOUT_US + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ir_n,
   input  logic             us_tick,
   output logic             edge_p,
   output logic             ended_mark,
   output logic [CNT_W-1:0] dur,
   output logic             stale
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   mark_now;
   logic                   mark_q;
   logic [CNT_W-1:0]       cnt;

   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be 1 to 4");
   end

   if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '1;
         else        sync_q <= ir_n;
      end
   end else begin : g_sync_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '1;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], ir_n};
      end
   end

   assign mark_now   = ~sync_q[SYNC_STAGES-1];
   assign edge_p     = mark_now != mark_q;
   assign ended_mark = mark_q;
   assign dur        = cnt;
   assign stale      = cnt >= CNT_W'(TIMEOUT_US);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mark_q <= 1'b0;
         cnt    <= '0;
      end else begin
         mark_q <= mark_now;
         if (edge_p)
            cnt <= us_tick ? CNT_W'(1) : '0;
         else if (us_tick && cnt != '1)
            cnt <= cnt + 1'b1;
      end
   end

   // R10: a measured phase restarts from the edge that ends the previous one
   p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
      edge_p |=> cnt <= CNT_W'(1));

endmodule

// File: rtl/ir_nec_fsm.sv
module ir_nec_fsm
   import ir_key_pkg::*;
#(
   parameter int LEAD_MARK_US  = 9000,
   parameter int LEAD_SPACE_US = 4500,
   parameter int REP_SPACE_US  = 2250,
   parameter int BIT_MARK_US   = 563,
   parameter int ZERO_SPACE_US = 563,
   parameter int ONE_SPACE_US  = 1688,
   parameter int TOL_PCT       = 20,
   parameter int CNT_W         = 14
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  edge_p,
   input  logic                  ended_mark,
   input  logic [CNT_W-1:0]      dur,
   input  logic                  stale,
   output logic                  frame_evt,
   output logic [FRAME_BITS-1:0] frame_data,
   output logic                  repeat_evt
);

   localparam int IDX_W = $clog2(FRAME_BITS);

   nec_state_e              st;
   logic [IDX_W-1:0]        bit_idx;
   logic [FRAME_BITS-1:0]   shreg;
   int                      d;
   logic                    is0, is1, lead_ok, rep_ok, bmark_ok;

   assign d          = int'(dur);
   assign lead_ok    = in_win(d, LEAD_SPACE_US, TOL_PCT);
   assign rep_ok     = in_win(d, REP_SPACE_US, TOL_PCT);
   assign bmark_ok   = in_win(d, BIT_MARK_US, TOL_PCT);
   assign is0        = in_win(d, ZERO_SPACE_US, TOL_PCT);
   assign is1        = in_win(d, ONE_SPACE_US, TOL_PCT);
   assign frame_data = shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= S_IDLE;
         bit_idx    <= '0;
         shreg      <= '0;
         frame_evt  <= 1'b0;
         repeat_evt <= 1'b0;
      end else begin
         frame_evt  <= 1'b0;
         repeat_evt <= 1'b0;
         if (st != S_IDLE && stale) begin
            st <= S_IDLE;
         end else if (edge_p) begin
            unique case (st)
               S_IDLE: begin
                  if (ended_mark && in_win(d, LEAD_MARK_US, TOL_PCT))
                     st <= S_LEAD_SPACE;
               end
               S_LEAD_SPACE: begin
                  if (!ended_mark && lead_ok) begin
                     st      <= S_BIT_MARK;
                     bit_idx <= '0;
                  end else if (!ended_mark && rep_ok) begin
                     repeat_evt <= 1'b1;
                     st         <= S_IDLE;
                  end else begin
                     st <= S_IDLE;
                  end
               end
               S_BIT_MARK: begin
                  st <= (ended_mark && bmark_ok) ? S_BIT_SPACE : S_IDLE;
               end
               S_BIT_SPACE: begin
                  if (!ended_mark && (is0 || is1)) begin
                     shreg <= {is1, shreg[FRAME_BITS-1:1]};
                     if (bit_idx == IDX_W'(FRAME_BITS - 1)) begin
                        frame_evt <= 1'b1;
                        st        <= S_IDLE;
                     end else begin
                        bit_idx <= bit_idx + 1'b1;
                        st      <= S_BIT_MARK;
                     end
                  end else begin
                     st <= S_IDLE;
                  end
               end
               default: st <= S_IDLE;
            endcase
         end
      end
   end

   // R10: a stalled frame drops back to idle on the next cycle
   p_timeout_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st != S_IDLE && stale) |=> st == S_IDLE);

   // R4: a complete frame is reported only out of the bit-space state
   p_frame_after_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_evt |-> $past(st) == S_BIT_SPACE);

   // R7: repeat and full-frame strobes never coincide
   p_evt_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_evt && repeat_evt));

endmodule

// File: rtl/ir_key_map.sv
module ir_key_map #(
   parameter int NUM_KEYS = 9,
   parameter logic [NUM_KEYS-1:0][7:0] CMD_TABLE  = ir_key_pkg::DEF_CMD,
   parameter logic [NUM_KEYS-1:0][3:0] CODE_TABLE = ir_key_pkg::DEF_CODE
) (
   input  logic [7:0] cmd,
   output logic       hit,
   output logic [3:0] code
);

   logic [NUM_KEYS-1:0]      match;
   logic [NUM_KEYS-1:0][3:0] masked;

   for (genvar i = 0; i < NUM_KEYS; i++) begin : g_entry
      assign match[i]  = cmd == CMD_TABLE[i];
      assign masked[i] = match[i] ? CODE_TABLE[i] : 4'h0;
      for (genvar j = i + 1; j < NUM_KEYS; j++) begin : g_dup
         if (CMD_TABLE[i] == CMD_TABLE[j]) begin : g_bad
            $error("duplicate command byte in key table");
         end
      end
   end

   always_comb begin
      code = 4'h0;
      for (int i = 0; i < NUM_KEYS; i++) code = code | masked[i];
   end

   assign hit = |match;

endmodule

// File: rtl/ir_key_decoder.sv
module ir_key_decoder
   import ir_key_pkg::*;
#(
   parameter int LEAD_MARK_US     = 9000,
   parameter int LEAD_SPACE_US    = 4500,
   parameter int REP_SPACE_US     = 2250,
   parameter int BIT_MARK_US      = 563,
   parameter int ZERO_SPACE_US    = 563,
   parameter int ONE_SPACE_US     = 1688,
   parameter int TOL_PCT          = 20,
   parameter int TIMEOUT_US       = 12000,
   parameter int REPEAT_WINDOW_US = 110000,
   parameter int SYNC_STAGES      = 2,
   parameter int NUM_KEYS         = DEF_KEYS,
   parameter logic [NUM_KEYS-1:0][7:0] CMD_TABLE  = DEF_CMD,
   parameter logic [NUM_KEYS-1:0][3:0] CODE_TABLE = DEF_CODE
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ir_n,
   input  logic       us_tick,
   output logic [3:0] key,
   output logic       key_valid,
   output logic       irq
);

   localparam int CNT_W = $clog2(TIMEOUT_US + 2);
   localparam int WIN_W = $clog2(REPEAT_WINDOW_US + 1);

   if (TOL_PCT < 1 || TOL_PCT > 40) begin : g_bad_tol
      $error("TOL_PCT out of range");
   end
   if (win_hi(ZERO_SPACE_US, TOL_PCT) >= win_lo(ONE_SPACE_US, TOL_PCT)) begin : g_bad_bits
      $error("zero and one space windows overlap");
   end
   if (win_hi(REP_SPACE_US, TOL_PCT) >= win_lo(LEAD_SPACE_US, TOL_PCT)) begin : g_bad_rep
      $error("repeat and leader space windows overlap");
   end
   if (win_hi(LEAD_MARK_US, TOL_PCT) >= TIMEOUT_US) begin : g_bad_tmo
      $error("timeout shorter than leader mark window");
   end

   logic                  edge_p, ended_mark, stale;
   logic [CNT_W-1:0]      dur;
   logic                  frame_evt, repeat_evt;
   logic [FRAME_BITS-1:0] frame_data;
   logic                  map_hit, frame_ok;
   logic [3:0]            map_code;
   logic [WIN_W-1:0]      win_cnt;

   ir_edge_timer #(
      .SYNC_STAGES(SYNC_STAGES),
      .TIMEOUT_US (TIMEOUT_US)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .ir_n      (ir_n),
      .us_tick   (us_tick),
      .edge_p    (edge_p),
      .ended_mark(ended_mark),
      .dur       (dur),
      .stale     (stale)
   );

   ir_nec_fsm #(
      .LEAD_MARK_US (LEAD_MARK_US),
      .LEAD_SPACE_US(LEAD_SPACE_US),
      .REP_SPACE_US (REP_SPACE_US),
      .BIT_MARK_US  (BIT_MARK_US),
      .ZERO_SPACE_US(ZERO_SPACE_US),
      .ONE_SPACE_US (ONE_SPACE_US),
      .TOL_PCT      (TOL_PCT),
      .CNT_W        (CNT_W)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .edge_p    (edge_p),
      .ended_mark(ended_mark),
      .dur       (dur),
      .stale     (stale),
      .frame_evt (frame_evt),
      .frame_data(frame_data),
      .repeat_evt(repeat_evt)
   );

   ir_key_map #(
      .NUM_KEYS  (NUM_KEYS),
      .CMD_TABLE (CMD_TABLE),
      .CODE_TABLE(CODE_TABLE)
   ) u_map (
      .cmd (frame_data[23:16]),
      .hit (map_hit),
      .code(map_code)
   );

   assign frame_ok = (frame_data[7:0]   == ~frame_data[15:8]) &&
                     (frame_data[23:16] == ~frame_data[31:24]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key       <= 4'h0;
         key_valid <= 1'b0;
         irq       <= 1'b0;
         win_cnt   <= '0;
      end else begin
         irq <= 1'b0;
         if (us_tick && win_cnt != '0) win_cnt <= win_cnt - 1'b1;
         if (frame_evt && frame_ok) begin
            if (map_hit) begin
               key       <= map_code;
               key_valid <= 1'b1;
               irq       <= 1'b1;
               win_cnt   <= WIN_W'(REPEAT_WINDOW_US);
            end else begin
               win_cnt   <= '0;
            end
         end else if (repeat_evt && key_valid && win_cnt != '0) begin
            irq     <= 1'b1;
            win_cnt <= WIN_W'(REPEAT_WINDOW_US);
         end
      end
   end

   // R2: irq is a single-cycle pulse
   p_irq_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   // R2: irq never reports without a valid key
   p_irq_has_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> key_valid);

   // R5: key only moves right after a decoded frame
   p_key_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_evt |=> $stable(key));

   // R8: a repeat outside the window is silent
   p_repeat_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (repeat_evt && win_cnt == '0) |=> !irq);

endmodule

// File: tb/tb_ir_key_decoder.sv
module tb_ir_key_decoder;

   localparam int LM = 180;
   localparam int LS = 90;
   localparam int RS = 45;
   localparam int BM = 12;
   localparam int ZS = 12;
   localparam int OS = 34;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ir_n = 1'b1;
   logic       us_tick = 1'b1;
   logic [3:0] key;
   logic       key_valid;
   logic       irq;

   int checks = 0;
   int failures = 0;
   int irq_cnt = 0;
   int wide_cnt = 0;
   logic irq_prev = 1'b0;

   always #4 clk = ~clk;

   ir_key_decoder #(
      .LEAD_MARK_US    (LM),
      .LEAD_SPACE_US   (LS),
      .REP_SPACE_US    (RS),
      .BIT_MARK_US     (BM),
      .ZERO_SPACE_US   (ZS),
      .ONE_SPACE_US    (OS),
      .TOL_PCT         (20),
      .TIMEOUT_US      (240),
      .REPEAT_WINDOW_US(2000)
   ) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .ir_n     (ir_n),
      .us_tick  (us_tick),
      .key      (key),
      .key_valid(key_valid),
      .irq      (irq)
   );

   always @(posedge clk) begin
      if (irq) irq_cnt <= irq_cnt + 1;
      if (irq && irq_prev) wide_cnt <= wide_cnt + 1;
      irq_prev <= irq;
   end

   // {addr, cmd, complement xor, expected irq count, expected key}
   localparam int NV = 13;
   localparam logic [39:0] VEC [NV] = '{
      {8'h00, 8'h45, 8'h00, 8'd1, 8'h7},
      {8'h00, 8'h0C, 8'h00, 8'd1, 8'h1},
      {8'h00, 8'h18, 8'h00, 8'd1, 8'h2},
      {8'h10, 8'h5E, 8'h00, 8'd1, 8'h3},
      {8'h00, 8'h1C, 8'h00, 8'd1, 8'h5},
      {8'h00, 8'h46, 8'h00, 8'd1, 8'h6},
      {8'h00, 8'h15, 8'h00, 8'd1, 8'h4},
      {8'hA5, 8'h44, 8'h00, 8'd1, 8'h8},
      {8'h00, 8'h43, 8'h00, 8'd1, 8'h9},
      {8'h00, 8'h45, 8'h01, 8'd0, 8'h9},
      {8'h00, 8'h99, 8'h00, 8'd0, 8'h9},
      {8'h00, 8'h0C, 8'h80, 8'd0, 8'h9},
      {8'h00, 8'h0C, 8'h00, 8'd1, 8'h1}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic mark(input int n);
      ir_n = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic space(input int n);
      ir_n = 1'b1;
      repeat (n) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] a, input logic [7:0] c,
                             input logic [7:0] ax, input logic [7:0] cx,
                             input int lead, input int one_len);
      logic [31:0] w;
      w = {(~c) ^ cx, c, (~a) ^ ax, a};
      mark(lead);
      space(LS);
      for (int i = 0; i < 32; i++) begin
         mark(BM);
         space(w[i] ? one_len : ZS);
      end
      mark(BM);
      space(30);
   endtask

   task automatic send_repeat();
      mark(LM);
      space(RS);
      mark(BM);
      space(30);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      int base;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(key == 4'h0, "R1 key", key, 0);
      chk(key_valid == 1'b0, "R1 key_valid", key_valid, 0);
      chk(irq == 1'b0, "R1 irq", irq, 0);

      // R8: repeat with no key yet
      space(40);
      base = irq_cnt;
      send_repeat();
      chk(irq_cnt - base == 0, "R8 repeat before key", irq_cnt - base, 0);
      chk(key_valid == 1'b0, "R8 key_valid", key_valid, 0);

      // Table walk: R2, R3, R4 (LSB-first codes), R5, R6
      for (int v = 0; v < NV; v++) begin
         string tag;
         base = irq_cnt;
         send_frame(VEC[v][39:32], VEC[v][31:24], 8'h00, VEC[v][23:16], LM, OS);
         tag = (VEC[v][15:8] != 0) ? "R3" : (VEC[v][23:16] != 0) ? "R5" : "R6";
         chk(irq_cnt - base == int'(VEC[v][15:8]), {tag, " irq count"},
             irq_cnt - base, int'(VEC[v][15:8]));
         chk(key == VEC[v][3:0], {tag, " key"}, key, VEC[v][3:0]);
         chk(key_valid, "R2 key_valid", key_valid, 1);
      end

      // R5: address complement mismatch
      base = irq_cnt;
      send_frame(8'h00, 8'h45, 8'h01, 8'h00, LM, OS);
      chk(irq_cnt - base == 0, "R5 addr mismatch irq", irq_cnt - base, 0);
      chk(key == 4'h1, "R5 addr mismatch key", key, 1);

      // R6: unmapped frame closes the repeat window
      send_frame(8'h00, 8'h99, 8'h00, 8'h00, LM, OS);
      base = irq_cnt;
      send_repeat();
      chk(irq_cnt - base == 0, "R6 repeat after unmapped", irq_cnt - base, 0);

      // R7: repeat inside the window, and restart of the window
      send_frame(8'h00, 8'h1C, 8'h00, 8'h00, LM, OS);
      space(1500);
      base = irq_cnt;
      send_repeat();
      chk(irq_cnt - base == 1, "R7 repeat in window", irq_cnt - base, 1);
      chk(key == 4'h5, "R7 repeat key", key, 5);
      space(1500);
      base = irq_cnt;
      send_repeat();
      chk(irq_cnt - base == 1, "R7 window restarted", irq_cnt - base, 1);

      // R8: window expired
      space(2500);
      base = irq_cnt;
      send_repeat();
      chk(irq_cnt - base == 0, "R8 repeat expired", irq_cnt - base, 0);
      chk(key == 4'h5, "R8 key held", key, 5);

      // R9: tolerance on the leader and bit spaces
      base = irq_cnt;
      send_frame(8'h00, 8'h46, 8'h00, 8'h00, 120, OS);
      chk(irq_cnt - base == 0, "R9 short leader", irq_cnt - base, 0);
      send_frame(8'h00, 8'h46, 8'h00, 8'h00, LM, 50);
      chk(irq_cnt - base == 0, "R9 long one space", irq_cnt - base, 0);
      chk(key == 4'h5, "R9 key held", key, 5);
      send_frame(8'h00, 8'h46, 8'h00, 8'h00, 200, OS);
      chk(irq_cnt - base == 1, "R9 leader within tolerance", irq_cnt - base, 1);
      chk(key == 4'h6, "R9 key", key, 6);

      // R10: abandoned frame times out, next frame decodes
      mark(LM);
      space(LS);
      for (int i = 0; i < 8; i++) begin
         mark(BM);
         space(ZS);
      end
      mark(BM);
      space(300);
      base = irq_cnt;
      send_frame(8'h00, 8'h44, 8'h00, 8'h00, LM, OS);
      chk(irq_cnt - base == 1, "R10 frame after timeout", irq_cnt - base, 1);
      chk(key == 4'h8, "R10 key", key, 8);

      // R2: every irq was a single cycle
      chk(wide_cnt == 0, "R2 irq width", wide_cnt, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule